// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. It finds out whether an embedded program or erase inside the flash has finished. After a start request it reads the flash status byte in pairs over a simple bus master port. It compares the toggle bit between the two reads of each pair. When the toggle bit stops changing, the operation is over.

Toggling can stop in the same cycle that the overtime flag (status bit 5) goes high. For that reason the block does not report failure as soon as it sees that flag. It first takes one more pair of reads. Only if the bit is still changing in that pair does it issue the flash reset command and report failure.

The result comes back as a one-cycle pulse on `done`, `fail` or `timedOut`. `timedOut` fires when a configurable number of toggling pairs pass without any outcome, so a flash that never responds cannot hang the block. A mode input chooses which status bit is watched: bit 6, which shows any embedded activity, or bit 2, which changes only at addresses inside sectors chosen for erase.

Top module: `tbp_poller`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `timedOut`, `busRd` and `busWr` are all low.
- R2: A `start` seen while idle sets `busy` from the next cycle and begins a pair of status reads. If the watched bit has the same value in both reads, `done` pulses after exactly two reads, and no write is issued.
- R3: If the watched bit differs within a pair and bit 5 of the pair's second read is 0, the block starts another pair. It continues to do so until a pair matches.
- R4: If the watched bit differs and bit 5 of the second read is 1, the block takes exactly one more pair. If that pair matches, `done` pulses and no write is issued.
- R5: If that extra pair still differs, its bit 5 is ignored. The block issues one bus write of 0xF0 and then pulses `fail` in the cycle after the write completes.
- R6: With `useSectorBit` = 0 the watched bit is bit 6 and bit 2 is ignored. With `useSectorBit` = 1 the watched bit is bit 2 and bit 6 is ignored.
- R7: When the pair that leaves the block waiting is the MAX_PAIRS-th toggling pair with bit 5 = 0, `timedOut` pulses. That takes 2*MAX_PAIRS reads, and no write is issued.
- R8: A read or write strobe stays asserted while `busWait` is high, and the two strobes are never high together. Every access uses the `statusAddr` latched at start.
- R9: A `start` during a run changes neither its address, its mode nor its outcome. Every accepted start begins again with a fresh pair of reads.
- R10: Exactly one of `done`, `fail` or `timedOut` pulses per run, for a single cycle, and `busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a status check; only accepted while idle |
| statusAddr | input | ADDR_W | Address used for all status reads and the reset write |
| useSectorBit | input | 1 | 0: watch bit 6; 1: watch bit 2 |
| busy | output | 1 | High from the cycle after an accepted start until the result |
| done | output | 1 | One-cycle pulse: operation completed |
| fail | output | 1 | One-cycle pulse: operation failed, reset command written |
| timedOut | output | 1 | One-cycle pulse: poll limit reached |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Bus write data (0xF0 during the reset write) |
| busRdata | input | DATA_W | Bus read data, valid in the cycle `busWait` is low |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busWait | input | 1 | Stretches the current access while high |

## Verification
The bench builds the block with MAX_PAIRS = 4, ADDR_W = 12 and DATA_W = 8. The small limit makes the timeout reachable in eight reads. That short run is also long enough to inject a second start in the middle of it. A bus model that alternates `busWait` on some runs stretches every access, which shows that strobes are held and that read counts do not depend on latency. Status sequences are chosen so that bit 2 and bit 6 disagree, and so that bit 5 appears both in a normal pair and in the extra pair after the flag.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  // watched status bits and the overtime flag
  localparam int BIT_ACTIVITY = 6;
  localparam int BIT_SECTOR   = 2;
  localparam int BIT_OVERTIME = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_RSTWR
  } tbpState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCfg;
    logic capFirst;
    logic clrCount;
    logic incCount;
  } tbpStrobe_t;

endpackage

// File: rtl/tbp_datapath.sv
module tbp_datapath
  import tbp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_PAIRS = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  tbpStrobe_t        stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              startAlt,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] holdAddr,
  output logic              bitMatch,
  output logic              overFlag,
  output logic              limitHit
);

  localparam int CNT_W = $clog2(MAX_PAIRS + 1);

  logic [ADDR_W-1:0] addrQ;
  logic              altQ;
  logic              firstBit;
  logic [CNT_W-1:0]  pairCnt;
  logic              selBit;
  logic              unusedBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      altQ     <= 1'b0;
      firstBit <= 1'b0;
      pairCnt  <= '0;
    end else begin
      if (stb.loadCfg) begin
        addrQ <= startAddr;
        altQ  <= startAlt;
      end
      if (stb.capFirst) firstBit <= selBit;
      if (stb.clrCount)      pairCnt <= '0;
      else if (stb.incCount) pairCnt <= pairCnt + 1'b1;
    end
  end

  assign selBit     = altQ ? rdData[BIT_SECTOR] : rdData[BIT_ACTIVITY];
  assign bitMatch   = (selBit == firstBit);
  assign overFlag   = rdData[BIT_OVERTIME];
  assign limitHit   = (pairCnt == CNT_W'(MAX_PAIRS - 1));
  assign holdAddr   = addrQ;
  assign unusedBits = ^rdData;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pairCnt < CNT_W'(MAX_PAIRS)); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadCfg |=> $stable(holdAddr)); // R8

endmodule

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
  import tbp_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              busWait,
  input  logic              bitMatch,
  input  logic              overFlag,
  input  logic              limitHit,
  output tbpStrobe_t        stb,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              timedOut
);

  tbpState_t state, nextState;
  logic recheckQ, setRecheck;
  logic setDone, setFail, setTo;

  always_comb begin
    nextState  = state;
    stb        = '0;
    busRd      = 1'b0;
    busWr      = 1'b0;
    setRecheck = 1'b0;
    setDone    = 1'b0;
    setFail    = 1'b0;
    setTo      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.loadCfg  = 1'b1;
          stb.clrCount = 1'b1;
          nextState    = ST_RDA;
        end
      end
      ST_RDA: begin
        busRd = 1'b1;
        if (!busWait) begin
          stb.capFirst = 1'b1;
          nextState    = ST_RDB;
        end
      end
      ST_RDB: begin
        busRd = 1'b1;
        if (!busWait) begin
          if (bitMatch) begin
            setDone   = 1'b1;
            nextState = ST_IDLE;
          end else if (recheckQ) begin
            nextState = ST_RSTWR;
          end else if (overFlag) begin
            setRecheck = 1'b1;
            nextState  = ST_RDA;
          end else if (limitHit) begin
            setTo     = 1'b1;
            nextState = ST_IDLE;
          end else begin
            stb.incCount = 1'b1;
            nextState    = ST_RDA;
          end
        end
      end
      ST_RSTWR: begin
        busWr = 1'b1;
        if (!busWait) begin
          setFail   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      recheckQ <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      state    <= nextState;
      done     <= setDone;
      fail     <= setFail;
      timedOut <= setTo;
      if (stb.loadCfg)  recheckQ <= 1'b0;
      else if (setRecheck) recheckQ <= 1'b1;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign busWdata = busWr ? DATA_W'(RESET_CMD) : '0;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr)); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busWait |=> busRd); // R8

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busWait |=> busWr); // R8

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, fail, timedOut})); // R10

  AST_IDLE_AT_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (done || fail || timedOut) |-> !busy); // R10

  AST_FAIL_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> $past(busWr && !busWait)); // R5

endmodule

// File: rtl/tbp_poller.sv
module tbp_poller
  import tbp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_PAIRS = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] statusAddr,
  input  logic              useSectorBit,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              timedOut,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busRd,
  output logic              busWr,
  input  logic              busWait
);

  tbpStrobe_t stb;
  logic bitMatch, overFlag, limitHit;

  tbp_ctrl #(.DATA_W(DATA_W), .RESET_CMD(8'hF0)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busWait(busWait),
    .bitMatch(bitMatch), .overFlag(overFlag), .limitHit(limitHit),
    .stb(stb), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busy(busy), .done(done), .fail(fail), .timedOut(timedOut)
  );

  tbp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PAIRS(MAX_PAIRS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startAddr(statusAddr),
    .startAlt(useSectorBit), .rdData(busRdata), .holdAddr(busAddr),
    .bitMatch(bitMatch), .overFlag(overFlag), .limitHit(limitHit)
  );

endmodule

// File: tb/tbp_poller_tb.sv
module tbp_poller_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 8;
  localparam int MAX_PAIRS  = 4;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] statusAddr = '0;
  logic useSectorBit = 1'b0;
  logic busy, done, fail, timedOut, busRd, busWr;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata, busRdata;
  logic busWait = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbp_poller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PAIRS(MAX_PAIRS)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .statusAddr(statusAddr),
    .useSectorBit(useSectorBit), .busy(busy), .done(done), .fail(fail),
    .timedOut(timedOut), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busRd(busRd), .busWr(busWr), .busWait(busWait)
  );

  typedef struct {
    string req;
    int    kind;   // 1 done, 2 fail, 3 timeout
    int    reads;
    int    writes;
    int    rdBase;
    int    wrBase;
  } expItem_t;

  expItem_t expQ[$];
  logic [7:0] pat[$];
  logic [7:0] statMem [64];
  logic [5:0] rdPtr = '0;
  logic [5:0] fillPtr = '0;
  int readCnt = 0, wrCnt = 0, badAddr = 0, resultCnt = 0, cyc = 0;
  int checks = 0, fails = 0;
  logic [ADDR_W-1:0] expAddr = '0;
  logic [7:0] lastWdata = '0;
  bit waitOn = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flash status model
  assign busRdata = statMem[rdPtr];

  always @(posedge clk) begin
    if (rstN) begin
      if (busRd && !busWait) begin
        readCnt++;
        rdPtr <= rdPtr + 1'b1;
        if (busAddr !== expAddr) badAddr++;
      end
      if (busWr && !busWait) begin
        wrCnt++;
        lastWdata <= busWdata;
        if (busAddr !== expAddr) badAddr++;
      end
    end
  end

  always @(negedge clk) busWait <= waitOn ? ~busWait : 1'b0;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && (done || fail || timedOut)) begin
      resultCnt++;
      if (expQ.size() == 0) begin
        chk(1'b0, "R10 unexpected result", 1, 0);
      end else begin
        expItem_t e;
        int kind;
        e = expQ.pop_front();
        kind = done ? 1 : (fail ? 2 : 3);
        chk(kind == e.kind, {e.req, " outcome kind"}, kind, e.kind);
        chk(readCnt - e.rdBase == e.reads, {e.req, " read count"}, readCnt - e.rdBase, e.reads);
        chk(wrCnt - e.wrBase == e.writes, {e.req, " write count"}, wrCnt - e.wrBase, e.writes);
        if (e.writes > 0)
          chk(lastWdata == 8'hF0, "R5 reset command data", lastWdata, 8'hF0);
        chk(busy == 1'b0, "R10 busy low at result", busy, 0);
      end
    end
  end

  task automatic runCase(input string req, input logic [ADDR_W-1:0] addr, input bit alt,
                         input int kind, input int reads, input int writes, input bit dblStart);
    int prev;
    expItem_t e;
    foreach (pat[i]) begin
      statMem[fillPtr] = pat[i];
      fillPtr = fillPtr + 1'b1;
    end
    expAddr = addr;
    e.req = req; e.kind = kind; e.reads = reads; e.writes = writes;
    e.rdBase = readCnt; e.wrBase = wrCnt;
    expQ.push_back(e);
    prev = resultCnt;
    @(negedge clk);
    start = 1'b1; statusAddr = addr; useSectorBit = alt;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    if (dblStart) begin
      repeat (2) @(negedge clk);
      start = 1'b1; statusAddr = ~addr; useSectorBit = ~alt;
      @(negedge clk);
      start = 1'b0;
    end
    while (resultCnt == prev) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(resultCnt == prev + 1, "R10 single result per run", resultCnt - prev, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      chk(1'b0, "watchdog expired", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (statMem[i]) statMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0 && fail == 0 && timedOut == 0, "R1 result pulses", done | fail | timedOut, 0);
    chk(busRd == 0 && busWr == 0, "R1 strobes", busRd | busWr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 immediate match on bit 6
    pat = '{8'h40, 8'h40};
    runCase("R2", 12'h100, 1'b0, 1, 2, 0, 1'b0);
    // R3 toggling pairs with bit 5 clear, stretched accesses
    waitOn = 1'b1;
    pat = '{8'h00, 8'h40, 8'h40, 8'h00, 8'h44, 8'h44};
    runCase("R3", 12'h2A4, 1'b0, 1, 6, 0, 1'b0);
    // R3 bit 5 only on first read of pair does not trigger recheck
    waitOn = 1'b0;
    pat = '{8'h20, 8'h40, 8'h60, 8'h60};
    runCase("R3", 12'h011, 1'b0, 1, 4, 0, 1'b0);
    // R4 overtime flag then toggling stops
    pat = '{8'h00, 8'h60, 8'h20, 8'h20};
    runCase("R4", 12'h3F0, 1'b0, 1, 4, 0, 1'b0);
    // R5 overtime flag then still toggling
    waitOn = 1'b1;
    pat = '{8'h00, 8'h60, 8'h20, 8'h60};
    runCase("R5", 12'h555, 1'b0, 2, 4, 1, 1'b0);
    // R5 extra pair toggles without bit 5: still failure
    waitOn = 1'b0;
    pat = '{8'h00, 8'h60, 8'h00, 8'h40};
    runCase("R5", 12'h0AA, 1'b0, 2, 4, 1, 1'b0);
    // R6 sector bit: bit 2 steady, bit 6 changing
    pat = '{8'h04, 8'h44};
    runCase("R6", 12'h800, 1'b1, 1, 2, 0, 1'b0);
    // R6 sector bit toggles, activity bit steady
    pat = '{8'h40, 8'h44, 8'h00, 8'h00};
    runCase("R6", 12'h804, 1'b1, 1, 4, 0, 1'b0);
    // R6 activity bit mode ignores bit 2
    pat = '{8'h04, 8'h00};
    runCase("R6", 12'h808, 1'b0, 1, 2, 0, 1'b0);
    // R7 poll limit, with R9 start injected mid-run
    waitOn = 1'b1;
    pat = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
    runCase("R7", 12'h123, 1'b0, 3, 8, 0, 1'b1);
    // R9 fresh pair after a timed-out run
    waitOn = 1'b0;
    pat = '{8'h40, 8'h40};
    runCase("R9", 12'h321, 1'b0, 1, 2, 0, 1'b0);

    chk(badAddr == 0, "R8 access address", badAddr, 0);
    chk(expQ.size() == 0, "R10 all runs reported", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule